// File: doc/BRIEF.md
# Flush-to-Zero Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point numbers in a generalized binary format. The exponent width and the significand width are parameters. The significand width counts the implicit leading one, so a word is one sign bit, then `EXP_W` exponent bits, then `FRAC_W-1` stored fraction bits. The exponent bias is `2^(EXP_W-1)-1`. A normal number has the value `(-1)^s * 2^(e-bias) * 1.f`.

Subtraction is done by flipping the sign of B before a single add path. The path orders the operands by magnitude and shifts the smaller one right, keeping guard, round and sticky bits. It then adds, normalizes with a leading-zero count and rounds to nearest with ties to even.

Subnormal numbers are not supported in either direction. Subnormal inputs count as zero with their sign, and results too small to be normal become a signed zero. Every NaN is quiet. The NaN that the block produces is always the same pattern. The pipeline advances only while `ce` is high, and `sclr` empties it on the next clock edge whatever `ce` is.

Top module: `fpadd_ftz`

## Requirements
- R1: A sample presented with `in_valid` high and accepted at a clock edge where `ce` is high appears on `result`, with `out_valid` high, after the sixth `ce`-enabled edge counting the accepting one. `out_valid` is low for every slot that was accepted with `in_valid` low.
- R2: While `ce` is low, `result`, `out_valid` and the three flags keep their values, and no input is accepted.
- R3: At an edge where `sclr` is high, every pipeline stage is cleared regardless of `ce`. After that edge `out_valid`, `result` and all flags read zero.
- R4: For finite operands the result is the exact sum, rounded to nearest with ties to even, to `FRAC_W` significant bits (with the default widths, 1.0 + 2^-24 gives 1.0 and (1+2^-23) + 2^-24 gives 1+2^-22).
- R5: An input with exponent field 0 and a non-zero fraction is treated as a zero of the same sign.
- R6: A non-zero rounded result whose biased exponent is 0 or less is returned as a zero with the result's sign (exponent and fraction fields 0), and `underflow` is raised.
- R7: A rounded result whose biased exponent reaches the all-ones value is returned as infinity with the result's sign (exponent all ones, fraction 0), and `overflow` is raised. At most one of the three flags is high at a time.
- R8: Infinities of opposite effective sign give the canonical NaN and raise `invalid`. The canonical NaN has sign 1, exponent all ones, the fraction MSB set and every other fraction bit 0 (0xFFC00000 with the default widths).
- R9: A NaN operand (exponent all ones, fraction non-zero) in either position, with either operation, gives the canonical NaN with `invalid` low.
- R10: A zero sum of finite operands is +0 unless both operands are zeros of negative effective sign, in which case it is -0. No flag is raised.
- R11: With `op_sub` = 1 the result is A - B, obtained by inverting the sign of B. With `op_sub` = 0 the result is A + B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sclr | input | 1 | Synchronous clear of all pipeline stages, active high, overrides `ce` |
| ce | input | 1 | Clock enable; the pipeline advances only while high |
| a | input | EXP_W+FRAC_W | Operand A |
| b | input | EXP_W+FRAC_W | Operand B |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| in_valid | input | 1 | Marks the inputs as a sample |
| result | output | EXP_W+FRAC_W | Rounded sum or difference |
| out_valid | output | 1 | Marks `result` and the flags as a sample |
| overflow | output | 1 | Result was rounded to infinity |
| underflow | output | 1 | Result was flushed to zero |
| invalid | output | 1 | Meaningless operation produced NaN |

## Verification
The hardest behaviour to reach from the ports is rounding after a near-cancelling subtraction. In that case the left shift after alignment moves the sticky information into the round position, and a tie appears only for particular pairs of exponent distance and mantissa. Random stimulus from a uniform distribution almost never gets there. The stimulus therefore draws the exponent of B within a few steps of the exponent of A and mixes in operands near the largest and smallest normal numbers. It also adds directed tie cases for both parities. Each result is compared with an exact integer reference in the bench that rounds from the full remainder instead of from guard, round and sticky bits.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  // operand class after flush-to-zero
  typedef enum logic [1:0] {FC_ZERO, FC_NORM, FC_INF, FC_NAN} fclass_e;
  // special outcome that overrides the arithmetic path
  typedef enum logic [1:0] {SP_NONE, SP_NAN, SP_INV, SP_INF} spec_e;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 24,
  localparam int W = EXP_W + FRAC_W,
  localparam int X = FRAC_W + 3
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             sub,
  output logic [X:0]       sum,
  output logic [EXP_W-1:0] e_big,
  output logic             s_big,
  output logic             zsign,
  output logic             eff_sub,
  output spec_e            spec,
  output logic             spec_sign
);

  function automatic fclass_e classify(input logic [W-1:0] v);
    if (v[W-2 -: EXP_W] == '1) return (v[FRAC_W-2:0] != '0) ? FC_NAN : FC_INF;
    if (v[W-2 -: EXP_W] == '0) return FC_ZERO;
    return FC_NORM;
  endfunction

  // right shift keeping guard/round bits and folding the rest into sticky
  function automatic logic [X-1:0] shift_sticky(input logic [FRAC_W-1:0] m,
                                                input logic [EXP_W-1:0] d);
    logic [2*X-1:0] t;
    int sh;
    sh = (int'(d) > X) ? X : int'(d);
    t = {m, 3'b000, {X{1'b0}}} >> sh;
    return {t[2*X-1:X+1], t[X] | (|t[X-1:0])};
  endfunction

  fclass_e ca, cb;
  logic sa, sb, swap;
  logic [EXP_W-1:0] ea, eb, e_sml, diff;
  logic [FRAC_W-1:0] ma, mb, m_big, m_sml;
  logic s_sml;
  logic [X-1:0] sml_al;

  always_comb begin
    ca = classify(a);
    cb = classify(b);
    sa = a[W-1];
    sb = b[W-1] ^ sub;
    ea = (ca == FC_ZERO) ? '0 : a[W-2 -: EXP_W];
    eb = (cb == FC_ZERO) ? '0 : b[W-2 -: EXP_W];
    ma = (ca == FC_ZERO) ? '0 : {1'b1, a[FRAC_W-2:0]};
    mb = (cb == FC_ZERO) ? '0 : {1'b1, b[FRAC_W-2:0]};
  end

  assign swap    = {eb, mb} > {ea, ma};
  assign e_big   = swap ? eb : ea;
  assign e_sml   = swap ? ea : eb;
  assign m_big   = swap ? mb : ma;
  assign m_sml   = swap ? ma : mb;
  assign s_big   = swap ? sb : sa;
  assign s_sml   = swap ? sa : sb;
  assign diff    = e_big - e_sml;
  assign sml_al  = shift_sticky(m_sml, diff);
  assign eff_sub = s_big ^ s_sml;
  assign sum     = eff_sub ? ({1'b0, m_big, 3'b000} - {1'b0, sml_al})
                           : ({1'b0, m_big, 3'b000} + {1'b0, sml_al});
  assign zsign   = sa & sb;

  always_comb begin
    spec = SP_NONE;
    spec_sign = 1'b0;
    if (ca == FC_NAN || cb == FC_NAN) spec = SP_NAN;
    else if (ca == FC_INF && cb == FC_INF) begin
      if (sa != sb) spec = SP_INV;
      else begin spec = SP_INF; spec_sign = sa; end
    end else if (ca == FC_INF) begin spec = SP_INF; spec_sign = sa; end
    else if (cb == FC_INF) begin spec = SP_INF; spec_sign = sb; end
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 24,
  localparam int W = EXP_W + FRAC_W,
  localparam int X = FRAC_W + 3,
  localparam int EW2 = EXP_W + 2
) (
  input  logic [X:0]       sum,
  input  logic [EXP_W-1:0] e_big,
  input  logic             s_big,
  input  logic             zsign,
  input  spec_e            spec,
  input  logic             spec_sign,
  output logic [W-1:0]     res,
  output logic             ovf,
  output logic             unf,
  output logic             inv,
  output logic             norm_ok
);
  localparam logic signed [EW2-1:0] EMAX_S = EW2'(2**EXP_W - 1);
  localparam logic [W-1:0] QNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-2){1'b0}}};

  function automatic int lead_zeros(input logic [X-1:0] v);
    for (int i = X - 1; i >= 0; i--) if (v[i]) return X - 1 - i;
    return X;
  endfunction

  int lz;
  logic [X-1:0] norm;
  logic signed [EW2-1:0] exp_n, exp_r;
  logic [FRAC_W-1:0] mant;
  logic [FRAC_W:0] mant_r;
  logic [FRAC_W-2:0] frac;
  logic rnd_up, round_carry;

  always_comb begin
    lz = lead_zeros(sum[X-1:0]);
    if (sum[X]) begin
      norm  = {sum[X:2], sum[1] | sum[0]};
      exp_n = $signed({2'b00, e_big}) + EW2'(1);
    end else begin
      norm  = sum[X-1:0] << lz;
      exp_n = $signed({2'b00, e_big}) - EW2'(lz);
    end
    mant   = norm[X-1:3];
    // nearest, ties to even: guard set and (round | sticky | lsb)
    rnd_up = norm[2] & (norm[1] | norm[0] | mant[0]);
    mant_r = {1'b0, mant} + (FRAC_W+1)'(rnd_up);
    round_carry = mant_r[FRAC_W];
    exp_r  = round_carry ? exp_n + EW2'(1) : exp_n;
    frac   = round_carry ? '0 : mant_r[FRAC_W-2:0];
    norm_ok = mant_r[FRAC_W] | mant_r[FRAC_W-1];
  end

  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    inv = 1'b0;
    if (spec == SP_NAN || spec == SP_INV) begin
      res = QNAN;
      inv = (spec == SP_INV);
    end else if (spec == SP_INF) res = {spec_sign, {EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}};
    else if (sum == '0) res = {zsign, {(W-1){1'b0}}};
    else if (exp_r >= EMAX_S) begin
      res = {s_big, {EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}};
      ovf = 1'b1;
    end else if (exp_r <= EW2'(0)) begin
      res = {s_big, {(W-1){1'b0}}};
      unf = 1'b1;
    end else res = {s_big, exp_r[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fpadd_delay.sv
module fpadd_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             sclr,
  input  logic             ce,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (sclr) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else if (ce) begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/fpadd_ftz.sv
module fpadd_ftz
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int FRAC_W = 24,
  localparam int W = EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         sclr,
  input  logic         ce,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         op_sub,
  input  logic         in_valid,
  output logic [W-1:0] result,
  output logic         out_valid,
  output logic         overflow,
  output logic         underflow,
  output logic         invalid
);
  localparam int X = FRAC_W + 3;
  localparam int TAIL = 4;              // stages after the round logic
  localparam int OW = W + 4;
  localparam logic [W-1:0] QNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-2){1'b0}}};

  // stage 1: input capture
  logic [W-1:0] a_q, b_q;
  logic sub_q, v1;
  always_ff @(posedge clk) begin
    if (sclr) begin
      a_q <= '0; b_q <= '0; sub_q <= 1'b0; v1 <= 1'b0;
    end else if (ce) begin
      a_q <= a; b_q <= b; sub_q <= op_sub; v1 <= in_valid;
    end
  end

  logic [X:0] sum_c;
  logic [EXP_W-1:0] e_big_c;
  logic s_big_c, zsign_c, eff_sub_c, spsign_c;
  spec_e spec_c;

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .a(a_q), .b(b_q), .sub(sub_q), .sum(sum_c), .e_big(e_big_c), .s_big(s_big_c),
    .zsign(zsign_c), .eff_sub(eff_sub_c), .spec(spec_c), .spec_sign(spsign_c)
  );

  // stage 2: aligned sum
  logic [X:0] sum_q;
  logic [EXP_W-1:0] e_q;
  logic s_q, z_q, sps_q, v2;
  spec_e spec_q;
  always_ff @(posedge clk) begin
    if (sclr) begin
      sum_q <= '0; e_q <= '0; s_q <= 1'b0; z_q <= 1'b0; sps_q <= 1'b0;
      spec_q <= SP_NONE; v2 <= 1'b0;
    end else if (ce) begin
      sum_q <= sum_c; e_q <= e_big_c; s_q <= s_big_c; z_q <= zsign_c;
      sps_q <= spsign_c; spec_q <= spec_c; v2 <= v1;
    end
  end

  logic [W-1:0] res_c;
  logic ovf_c, unf_c, inv_c, norm_ok_c;

  fpadd_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sum(sum_q), .e_big(e_q), .s_big(s_q), .zsign(z_q), .spec(spec_q),
    .spec_sign(sps_q), .res(res_c), .ovf(ovf_c), .unf(unf_c), .inv(inv_c),
    .norm_ok(norm_ok_c)
  );

  // stages 3..6
  logic [OW-1:0] tail_q;
  fpadd_delay #(.WIDTH(OW), .DEPTH(TAIL)) u_tail (
    .clk(clk), .sclr(sclr), .ce(ce),
    .d({v2, ovf_c, unf_c, inv_c, res_c}), .q(tail_q)
  );
  assign {out_valid, overflow, underflow, invalid, result} = tail_q;

  // R4: magnitude ordering means a subtraction never borrows
  a_r4_no_borrow: assert property (@(posedge clk) disable iff (sclr)
    (eff_sub_c && spec_c == SP_NONE) |-> !sum_c[X]);
  // R4: a non-zero sum normalizes to a significand with its leading one set
  a_r4_normalized: assert property (@(posedge clk) disable iff (sclr)
    (spec_q == SP_NONE && sum_q != '0) |-> norm_ok_c);
  a_r7_ovf_inf: assert property (@(posedge clk) disable iff (sclr)
    overflow |-> result[W-2:0] == {{EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}});
  // R7: flags are mutually exclusive
  a_r7_flags_onehot: assert property (@(posedge clk) disable iff (sclr)
    $onehot0({overflow, underflow, invalid}));
  a_r6_unf_zero: assert property (@(posedge clk) disable iff (sclr)
    underflow |-> result[W-2:0] == '0);
  a_r8_inv_nan: assert property (@(posedge clk) disable iff (sclr)
    invalid |-> result == QNAN);
  a_r2_hold: assert property (@(posedge clk) disable iff (sclr)
    !ce |=> ($stable(result) && $stable(out_valid) && $stable(overflow)
             && $stable(underflow) && $stable(invalid)));
  a_r3_clear: assert property (@(posedge clk)
    sclr |=> (!out_valid && result == '0 && !overflow && !underflow && !invalid));
endmodule

// File: tb/fpadd_ftz_tb.sv
module fpadd_ftz_tb;
  // reference model is written for the default widths (8-bit exponent, 24-bit significand)
  logic clk = 1'b0;
  logic sclr = 1'b1;
  logic ce = 1'b1;
  logic [31:0] a = '0, b = '0;
  logic op_sub = 1'b0, in_valid = 1'b0;
  logic [31:0] result;
  logic out_valid, overflow, underflow, invalid;

  always #5 clk = ~clk;

  fpadd_ftz u_dut (
    .clk(clk), .sclr(sclr), .ce(ce), .a(a), .b(b), .op_sub(op_sub),
    .in_valid(in_valid), .result(result), .out_valid(out_valid),
    .overflow(overflow), .underflow(underflow), .invalid(invalid)
  );

  localparam logic [31:0] CNAN = 32'hFFC0_0000;
  int n_chk = 0, n_fail = 0;
  string cur_tag = "R4";
  string vtag = "R1";
  bit running = 1'b0;

  // exact reference: returns {ovf, unf, inv, result}
  function automatic logic [34:0] ref_add(input logic [31:0] x, input logic [31:0] y,
                                          input logic s);
    logic sx, sy, ts;
    int ex, ey, te, d, p, sh, e;
    logic [63:0] mx, my, tm, n, q, rem, half;
    bit nx, ny, ix, iy;
    sx = x[31]; sy = y[31] ^ s;
    ex = int'(x[30:23]); ey = int'(y[30:23]);
    nx = (ex == 255) && (x[22:0] != 0); ny = (ey == 255) && (y[22:0] != 0);
    ix = (ex == 255) && (x[22:0] == 0); iy = (ey == 255) && (y[22:0] == 0);
    if (nx || ny) return {3'b000, CNAN};
    if (ix && iy) return (sx != sy) ? {3'b001, CNAN} : {3'b000, sx, 8'hFF, 23'h0};
    if (ix) return {3'b000, sx, 8'hFF, 23'h0};
    if (iy) return {3'b000, sy, 8'hFF, 23'h0};
    mx = (ex == 0) ? 64'd0 : ({41'd0, 1'b1, x[22:0]});
    my = (ey == 0) ? 64'd0 : ({41'd0, 1'b1, y[22:0]});
    if (ex < ey || (ex == ey && mx < my)) begin
      te = ex; ex = ey; ey = te; tm = mx; mx = my; my = tm; ts = sx; sx = sy; sy = ts;
    end
    d = ex - ey;
    if (d > 27) begin d = 27; my = (my != 0) ? 64'd1 : 64'd0; end
    n = (sx == sy) ? ((mx << d) + my) : ((mx << d) - my);
    if (n == 0) return {3'b000, sx & sy, 31'd0};
    p = 0;
    for (int i = 63; i >= 0; i--) if (n[i]) begin p = i; break; end
    e = ex - d + p - 23;
    if (p > 23) begin
      sh = p - 23;
      q = n >> sh;
      rem = n & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && q[0])) q = q + 1;
      if (q == (64'd1 << 24)) begin q = q >> 1; e = e + 1; end
    end else q = n << (23 - p);
    if (e >= 255) return {3'b100, sx, 8'hFF, 23'h0};
    if (e <= 0) return {3'b010, sx, 31'd0};
    return {3'b000, sx, e[7:0], q[22:0]};
  endfunction

  // cycle model of the pipeline
  bit mv [6];
  logic [34:0] md [6];
  string mt [6];
  always @(posedge clk) begin
    if (sclr) begin
      for (int i = 0; i < 6; i++) begin mv[i] <= 1'b0; md[i] <= '0; mt[i] <= ""; end
    end else if (ce) begin
      mv[0] <= in_valid; md[0] <= ref_add(a, b, op_sub); mt[0] <= cur_tag;
      for (int i = 1; i < 6; i++) begin mv[i] <= mv[i-1]; md[i] <= md[i-1]; mt[i] <= mt[i-1]; end
    end
  end

  always @(negedge clk) if (running) begin
    n_chk++;
    if (out_valid !== mv[5]) begin
      n_fail++;
      $display("FAIL %s out_valid actual=%b expected=%b", vtag, out_valid, mv[5]);
    end else if (mv[5]) begin
      n_chk++;
      if ({overflow, underflow, invalid, result} !== md[5]) begin
        n_fail++;
        $display("FAIL %s result/flags actual=%b%b%b %h expected=%b %h", mt[5],
                 overflow, underflow, invalid, result, md[5][34:32], md[5][31:0]);
      end
    end
  end

  task automatic send(input logic [31:0] x, input logic [31:0] y, input logic s,
                      input string t);
    a = x; b = y; op_sub = s; in_valid = 1'b1; cur_tag = t;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] rnd_near(input logic [7:0] e0, input int span);
    logic [7:0] e;
    logic [31:0] r;
    r = $urandom;
    e = e0 + 8'($urandom_range(span, 0)) - 8'(span / 2);
    return {r[31], e, r[22:0]};
  endfunction

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3: outputs are zero after clear
    n_chk++;
    if ({out_valid, overflow, underflow, invalid, result} !== '0) begin
      n_fail++;
      $display("FAIL R3 reset state actual=%b%b%b%b %h expected=0", out_valid, overflow,
               underflow, invalid, result);
    end
    sclr = 1'b0;
    running = 1'b1;
    // directed cases
    send(32'h3F80_0000, 32'h3F80_0000, 1'b0, "R4");
    send(32'h3F80_0000, 32'h3380_0000, 1'b0, "R4");  // tie, even stays
    send(32'h3F80_0001, 32'h3380_0000, 1'b0, "R4");  // tie, odd rounds up
    send(32'h3F80_0000, 32'h3F80_0000, 1'b1, "R10"); // exact cancellation +0
    send(32'h8000_0000, 32'h8000_0000, 1'b0, "R10"); // -0 + -0
    send(32'h8000_0000, 32'h0000_0000, 1'b1, "R10"); // -0 - +0
    send(32'h0000_0000, 32'h8000_0000, 1'b0, "R10"); // +0 + -0
    send(32'h0000_0001, 32'h3F80_0000, 1'b0, "R5");
    send(32'h8000_0005, 32'h8000_0000, 1'b0, "R5");  // -denormal acts as -0
    send(32'h807F_FFFF, 32'h0000_0000, 1'b1, "R5");
    send(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, "R7");
    send(32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b1, "R7");
    send(32'h0080_0001, 32'h0080_0000, 1'b1, "R6");
    send(32'h8080_0001, 32'h0080_0000, 1'b0, "R6");
    send(32'h7F80_0000, 32'h7F80_0000, 1'b1, "R8");
    send(32'hFF80_0000, 32'h7F80_0000, 1'b0, "R8");
    send(32'h7F80_0000, 32'h3F80_0000, 1'b1, "R8");  // inf - finite stays inf
    send(32'h7FC0_0000, 32'h3F80_0000, 1'b0, "R9");
    send(32'h3F80_0000, 32'h7F80_0001, 1'b1, "R9");
    send(32'h7F80_0000, 32'hFF80_0001, 1'b0, "R9");
    send(32'h4000_0000, 32'h3F80_0000, 1'b1, "R11");
    send(32'h4000_0000, 32'hBF80_0000, 1'b1, "R11");
    send(32'h3F80_0000, 32'h4000_0000, 1'b1, "R11");
    idle(8);
    // R1: valid pattern with gaps
    vtag = "R1";
    for (int i = 0; i < 200; i++) begin
      a = rnd_near(8'd127, 60); b = rnd_near(a[30:23], 6);
      op_sub = 1'($urandom); in_valid = 1'($urandom); cur_tag = "R1";
      @(negedge clk);
    end
    idle(8);
    // R2: clock enable toggling
    vtag = "R2";
    for (int i = 0; i < 600; i++) begin
      a = rnd_near(8'd127, 40); b = rnd_near(a[30:23], 4);
      op_sub = 1'($urandom); in_valid = 1'($urandom); cur_tag = "R2";
      ce = ($urandom_range(3, 0) != 0);
      @(negedge clk);
    end
    ce = 1'b1;
    idle(8);
    // R4/R6/R7: random near-cancellation and extremes
    vtag = "R1";
    for (int i = 0; i < 4000; i++) begin
      case ($urandom_range(3, 0))
        0: a = rnd_near(8'd127, 100);
        1: a = rnd_near(8'd3, 6);
        2: a = rnd_near(8'd252, 6);
        default: a = $urandom;
      endcase
      b = ($urandom_range(4, 0) == 0) ? 32'($urandom) : rnd_near(a[30:23], 4);
      send(a, b, 1'($urandom), "R4");
    end
    // R3: clear in the middle of traffic
    for (int i = 0; i < 4; i++) send(32'h3F80_0000, 32'h4000_0000, 1'b0, "R3");
    sclr = 1'b1;
    @(negedge clk);
    sclr = 1'b0;
    n_chk++;
    if ({out_valid, overflow, underflow, invalid, result} !== '0) begin
      n_fail++;
      $display("FAIL R3 after clear actual=%b %h expected=0", out_valid, result);
    end
    vtag = "R3";
    idle(10);
    running = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule